// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives the pins of an external asynchronous memory (SRAM, flash, or a memory-mapped peripheral) for one access at a time. A 32-bit configuration word for the region sets the phase lengths. A request carries the direction, address, byte lanes and write data. The sequencer steps through three phases: setup, strobe and hold. During those phases it drives the active-low chip select, output enable, write enable and byte lines. For reads it returns the data captured at the end of the strobe. It then pulses a completion flag. Timeout limit, ready polarity and turnaround spacing come from separate static inputs.

The device can stretch the strobe phase with a ready input. A polarity input selects which level of that input means "wait". The stretch is bounded by a limit counted in blocks of 16 cycles. If the device is still waiting when the limit is reached, the access is cut short and a timeout flag pulses together with the completion flag. If the configuration word selects synchronous memory, the request is rejected with an error pulse and no pin activity.

The controller has six states. ST_IDLE accepts a request. ST_SETUP, ST_STROBE and ST_HOLD are the three pin phases. ST_DONE is the single completion cycle. ST_GAP holds the turnaround spacing. The transitions are:
- accept: ST_IDLE to ST_SETUP.
- setup-end: ST_SETUP to ST_STROBE.
- stretch: ST_STROBE to itself.
- strobe-end: ST_STROBE to ST_HOLD.
- abort: ST_STROBE to ST_DONE, on timeout.
- hold-end: ST_HOLD to ST_DONE.
- to-gap: ST_DONE to ST_GAP, when the turnaround field is not 0.
- to-idle: ST_DONE to ST_IDLE, when the turnaround field is 0.
- gap-end: ST_GAP to ST_IDLE.

Top module: `async_strobe_engine`

## Requirements
- R1: After reset the block is idle:
  - `busy`, `done`, `timeout`, `req_err` and `mem_dout_en` are 0.
  - `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_be_n` is all ones.
  - `rd_data` is 0.
- R2: A read accepted in cycle c (`req_valid`=1 in ST_IDLE) has three phases.
  - Setup starts in cycle c+1 and lasts cfg[14:11]+1 cycles.
  - Strobe follows and lasts cfg[10:5]+1 cycles plus any stretch. `mem_oe_n` is 0 only during the strobe.
  - Hold follows and lasts cfg[4:2]+1 cycles.
  - `mem_ce_n` and `mem_be_n` (active-low copy of the enabled lanes) stay asserted through all three phases.
- R3: A write uses cfg[27:24] for setup, cfg[23:18] for strobe and cfg[17:15] for hold, each plus one cycle.
  - `mem_we_n` is 0 only during the strobe.
  - `mem_dout_en` is 1 and `mem_dout` equals the request data from the first setup cycle to the last hold cycle.
- R4: Read data timing and completion:
  - `rd_data` takes the value of `mem_din` from the last strobe cycle, including any stretch.
  - `done` is high for exactly the one cycle that follows the last hold cycle. All strobes and the chip select are inactive in that cycle.
- R5: Strobe stretch:
  - Stretching is enabled when cfg[28]=1.
  - While the nominal strobe is over and `mem_rdy` equals `rdy_pol`, the strobe is extended by one cycle per such cycle.
  - `rdy_pol`=1 means wait while `mem_rdy` is high; `rdy_pol`=0 means wait while it is low.
- R6: Stretch limit and timeout:
  - The stretch is limited to `max_wait`×16 extra cycles. Reaching exactly the limit and then seeing the device release is a normal access.
  - If the device is still waiting once the limit is used up, the strobe ends there and the hold phase is skipped. `done` and `timeout` are then both high in the next cycle.
- R7: With cfg[28]=0, `mem_rdy` has no effect on any phase length.
- R8: Turnaround spacing:
  - Between the last hold cycle of one access and the first setup cycle of the next, at least `ta_cycles`+2 cycles pass with chip select and strobes inactive.
  - The gap is exactly that long when the next request is already waiting.
- R9: With cfg[29]=1, the byte lines act as byte write strobes:
  - `mem_be_n` shows the enabled lanes only during a write strobe.
  - `mem_be_n` is all ones at all other times, including reads.
- R10: With cfg[30]=1, `mem_ce_n` is asserted only during the strobe phase.
- R11: With cfg[31]=1, a request presented in ST_IDLE raises `req_err` in that same cycle (combinationally). It is otherwise ignored: no pin activity, no `done`, and `busy` stays 0.
- R12: `busy` is 1 from the cycle after acceptance until the block returns to ST_IDLE. Requests presented while `busy` is 1 do not change the running access.
- R13: cfg[1:0] selects the device width (0: 8, 1: 16, 2: 32, 3: 64 bit). Byte lanes at or above 2^cfg[1:0] are never asserted on `mem_be_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Region configuration word (static) |
| rdy_pol | input | 1 | Ready level that means "wait" |
| max_wait | input | 8 | Stretch limit in units of 16 cycles |
| ta_cycles | input | 3 | Turnaround field; gap is value + 2 cycles |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte lanes requested, active high |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Request cannot be accepted |
| req_err | output | 1 | Request refused (synchronous region) |
| mem_rdy | input | 1 | Device ready / wait input |
| mem_din | input | DATA_W | Data from device |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | BE_W | Byte lines, active low |
| mem_addr | output | ADDR_W | Address to device |
| mem_dout | output | DATA_W | Data to device |
| mem_dout_en | output | 1 | Data bus drive enable |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | Access complete pulse |
| timeout | output | 1 | Access ended by stretch limit |

## Verification
The hardest situation to reach is the exact boundary of the stretch limit. The device must still be waiting on the very cycle where the counted extension equals `max_wait`×16, and one cycle later the device must release. The bench drives `mem_rdy` from the same per-cycle schedule that predicts the pins. It can therefore hold the wait level for exactly 16 extension cycles, one more than that, or well past the limit with `max_wait`=0, and place the release on the exact cycle. Back-to-back requests are held on `req_valid` through the whole access and gap, which shows both the exact turnaround length and that busy-time requests are ignored.

// File: rtl/ase_pkg.sv
package ase_pkg;

    localparam int SU_W           = 4;
    localparam int SB_W           = 6;
    localparam int HD_W           = 3;
    localparam int TA_W           = 3;
    localparam int MW_W           = 8;
    localparam int WAIT_UNIT_LOG2 = 4;
    localparam int CNT_W          = SB_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [SU_W-1:0] setup;
        logic [SB_W-1:0] strobe;
        logic [HD_W-1:0] hold;
    } phase_len_t;

    typedef struct packed {
        phase_len_t rd;
        phase_len_t wr;
        logic       rdy_en;
        logic       lane_strobe;
        logic       ce_strobe_only;
        logic       sync_region;
        logic [1:0] width_sel;
    } region_cfg_t;

endpackage

// File: rtl/ase_cfg_unpack.sv
module ase_cfg_unpack
    import ase_pkg::*;
(
    input  logic [31:0]  cfg_word,
    output region_cfg_t  cfg
);
    always_comb begin
        cfg.width_sel      = cfg_word[1:0];
        cfg.rd.hold        = cfg_word[4:2];
        cfg.rd.strobe      = cfg_word[10:5];
        cfg.rd.setup       = cfg_word[14:11];
        cfg.wr.hold        = cfg_word[17:15];
        cfg.wr.strobe      = cfg_word[23:18];
        cfg.wr.setup       = cfg_word[27:24];
        cfg.rdy_en         = cfg_word[28];
        cfg.lane_strobe    = cfg_word[29];
        cfg.ce_strobe_only = cfg_word[30];
        cfg.sync_region    = cfg_word[31];
    end
endmodule

// File: rtl/ase_phase_counter.sv
module ase_phase_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign is_zero = (cnt == '0);
endmodule

// File: rtl/ase_wait_limit.sv
module ase_wait_limit #(
    parameter int MW_W      = 8,
    parameter int UNIT_LOG2 = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    input  logic [MW_W-1:0] max_wait,
    output logic            at_limit
);
    localparam int EXT_W = MW_W + UNIT_LOG2;

    logic [EXT_W-1:0] ext_cnt;
    logic [EXT_W-1:0] limit;

    assign limit = {max_wait, {UNIT_LOG2{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_cnt <= '0;
        end else if (clr) begin
            ext_cnt <= '0;
        end else if (inc) begin
            ext_cnt <= ext_cnt + 1'b1;
        end
    end

    assign at_limit = (ext_cnt == limit);
endmodule

// File: rtl/async_strobe_engine.sv
module async_strobe_engine
    import ase_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              rdy_pol,
    input  logic [MW_W-1:0]   max_wait,
    input  logic [TA_W-1:0]   ta_cycles,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              req_err,
    input  logic              mem_rdy,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              timeout
);
    region_cfg_t cfg;
    seq_state_e  st, st_nxt;

    logic              cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0]  cnt_val;
    logic              wt_clr, wt_inc, at_limit;
    logic              accept, abort, strobe_end, rdy_wait;
    logic              wr_q, tmo_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_q;
    logic [BE_W-1:0]   lane_on;
    logic [BE_W-1:0]   lanes_n;
    logic              in_access;

    ase_cfg_unpack i_unpack (
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    ase_phase_counter #(.W(CNT_W)) i_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero)
    );

    ase_wait_limit #(.MW_W(MW_W), .UNIT_LOG2(WAIT_UNIT_LOG2)) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wt_clr),
        .inc      (wt_inc),
        .max_wait (max_wait),
        .at_limit (at_limit)
    );

    // Lanes present on a device of the configured width
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_on[g] = (32'(g) < (32'd1 << cfg.width_sel));
    end

    assign accept   = (st == ST_IDLE) && req_valid && !cfg.sync_region;
    assign rdy_wait = (mem_rdy == rdy_pol);
    assign wt_clr   = (st != ST_STROBE);

    // Next state and counter control
    always_comb begin
        st_nxt     = st;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        cnt_dec    = 1'b0;
        wt_inc     = 1'b0;
        abort      = 1'b0;
        strobe_end = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    st_nxt   = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = req_write ? CNT_W'(cfg.wr.setup) : CNT_W'(cfg.rd.setup);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_nxt   = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = wr_q ? CNT_W'(cfg.wr.strobe) : CNT_W'(cfg.rd.strobe);
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_STROBE: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (cfg.rdy_en && rdy_wait) begin
                    if (at_limit) begin
                        st_nxt     = ST_DONE;
                        abort      = 1'b1;
                        strobe_end = 1'b1;
                    end else begin
                        wt_inc = 1'b1;
                    end
                end else begin
                    st_nxt     = ST_HOLD;
                    strobe_end = 1'b1;
                    cnt_load   = 1'b1;
                    cnt_val    = wr_q ? CNT_W'(cfg.wr.hold) : CNT_W'(cfg.rd.hold);
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    st_nxt = ST_DONE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_DONE: begin
                if (ta_cycles == '0) begin
                    st_nxt = ST_IDLE;
                end else begin
                    st_nxt   = ST_GAP;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(ta_cycles) - 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_zero) begin
                    st_nxt = ST_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Request capture, read sampling, timeout marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
            tmo_q   <= 1'b0;
        end else begin
            tmo_q <= abort;
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
            if (strobe_end && !wr_q) begin
                rd_q <= mem_din;
            end
        end
    end

    // Pin and status outputs
    always_comb begin
        in_access = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
        lanes_n   = ~(be_q & lane_on);

        mem_ce_n  = cfg.ce_strobe_only ? (st != ST_STROBE) : !in_access;
        mem_oe_n  = !((st == ST_STROBE) && !wr_q);
        mem_we_n  = !((st == ST_STROBE) && wr_q);
        if (cfg.lane_strobe) begin
            mem_be_n = ((st == ST_STROBE) && wr_q) ? lanes_n : '1;
        end else begin
            mem_be_n = in_access ? lanes_n : '1;
        end
        mem_dout_en = in_access && wr_q;
        mem_addr    = addr_q;
        mem_dout    = wdata_q;
        rd_data     = rd_q;
        busy        = (st != ST_IDLE);
        done        = (st == ST_DONE);
        timeout     = (st == ST_DONE) && tmo_q;
        req_err     = (st == ST_IDLE) && req_valid && cfg.sync_region;
    end

endmodule

// File: rtl/ase_checker.sv
module ase_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic req_err,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dout_en,
    input logic done,
    input logic timeout
);
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R2

    AST_OE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dout_en); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_PINS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en)); // R4

    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done); // R6

    AST_DONE_STILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8

    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> (!busy && mem_ce_n)); // R11

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_err) |=> busy); // R12
endmodule

bind async_strobe_engine ase_checker i_ase_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .req_err     (req_err),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout_en (mem_dout_en),
    .done        (done),
    .timeout     (timeout)
);

// File: tb/test_async_strobe_engine.sv
module test_async_strobe_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        rdy_pol = 1'b1;
    logic [7:0]  max_wait = '0;
    logic [2:0]  ta_cycles = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_rdy = 1'b0;
    logic [31:0] mem_din = '0;
    logic        busy, req_err, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, done, timeout;
    logic [3:0]  mem_be_n;
    logic [19:0] mem_addr;
    logic [31:0] mem_dout, rd_data;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    async_strobe_engine i_async_strobe_engine (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .rdy_pol(rdy_pol),
        .max_wait(max_wait), .ta_cycles(ta_cycles), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .busy(busy), .req_err(req_err), .mem_rdy(mem_rdy),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .rd_data(rd_data),
        .done(done), .timeout(timeout)
    );

    typedef struct {
        bit          req;
        bit          rdy;
        logic [31:0] din;
        bit          ce_n, oe_n, we_n;
        logic [3:0]  be_n;
        bit          dout_en, done, tmo, err, busy;
        bit          chk_rd;
        logic [31:0] rd;
        bit          chk_ad;
    } ent_t;

    ent_t q[$];

    function automatic ent_t idle_ent(bit busy_e);
        ent_t e;
        e.req = 1'b0; e.rdy = ~rdy_pol; e.din = 32'h0BAD_0000;
        e.ce_n = 1'b1; e.oe_n = 1'b1; e.we_n = 1'b1; e.be_n = 4'hF;
        e.dout_en = 1'b0; e.done = 1'b0; e.tmo = 1'b0; e.err = 1'b0;
        e.busy = busy_e; e.chk_rd = 1'b0; e.rd = '0; e.chk_ad = 1'b0;
        return e;
    endfunction

    function automatic logic [31:0] mk_cfg(int rsu, int rsb, int rh, int wsu, int wsb, int wh,
                                           bit ae, bit bwe, bit ss, bit sy, int sz);
        logic [31:0] c;
        c = '0;
        c[1:0] = 2'(sz); c[4:2] = 3'(rh); c[10:5] = 6'(rsb); c[14:11] = 4'(rsu);
        c[17:15] = 3'(wh); c[23:18] = 6'(wsb); c[27:24] = 4'(wsu);
        c[28] = ae; c[29] = bwe; c[30] = ss; c[31] = sy;
        return c;
    endfunction

    task automatic chk(string name, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, name, act, exp, $time);
        end
    endtask

    // One clock cycle: apply drive, then compare at the falling edge
    task automatic step();
        ent_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) e = q.pop_front();
        else e = idle_ent(1'b0);
        req_valid = e.req;
        mem_rdy   = e.rdy;
        mem_din   = e.din;
        @(negedge clk);
        chk("ce_n", 32'(mem_ce_n), 32'(e.ce_n));
        chk("oe_n", 32'(mem_oe_n), 32'(e.oe_n));
        chk("we_n", 32'(mem_we_n), 32'(e.we_n));
        chk("be_n", 32'(mem_be_n), 32'(e.be_n));
        chk("dout_en", 32'(mem_dout_en), 32'(e.dout_en));
        chk("done", 32'(done), 32'(e.done));
        chk("timeout", 32'(timeout), 32'(e.tmo));
        chk("req_err", 32'(req_err), 32'(e.err));
        chk("busy", 32'(busy), 32'(e.busy));
        if (e.chk_rd) chk("rd_data", rd_data, e.rd);
        if (e.chk_ad) begin
            chk("addr", 32'(mem_addr), 32'(req_addr));
            if (req_write) chk("dout", mem_dout, req_wdata);
        end
    endtask

    task automatic run_q();
        while (q.size() > 0) step();
    endtask

    // Behavioural prediction of one access from the requirements
    task automatic build(bit hold_req, int ext);
        ent_t        e;
        int          su, sb, hd, lim, extn;
        bit          tmo, wr, bwe, ss;
        logic [3:0]  mask, bev;
        logic [31:0] last_din;
        wr  = req_write;
        bwe = cfg_word[29];
        ss  = cfg_word[30];
        e = idle_ent(1'b0);
        e.req = 1'b1;
        if (cfg_word[31]) begin               // R11
            e.err = 1'b1;
            q.push_back(e);
            q.push_back(idle_ent(1'b0));
            return;
        end
        q.push_back(e);
        su  = 1 + int'(wr ? cfg_word[27:24] : cfg_word[14:11]);
        sb  = 1 + int'(wr ? cfg_word[23:18] : cfg_word[10:5]);
        hd  = 1 + int'(wr ? cfg_word[17:15] : cfg_word[4:2]);
        lim = int'(max_wait) * 16;
        if (cfg_word[28]) begin
            extn = (ext < lim) ? ext : lim;
            tmo  = (ext > lim);
        end else begin
            extn = 0;
            tmo  = 1'b0;
        end
        mask = '0;
        for (int i = 0; i < 4; i++) if (i < (1 << cfg_word[1:0])) mask[i] = 1'b1;
        bev = ~(req_be & mask);
        last_din = '0;
        for (int i = 0; i < su; i++) begin
            e = idle_ent(1'b1); e.req = hold_req; e.ce_n = ss;
            e.be_n = bwe ? 4'hF : bev; e.dout_en = wr; e.chk_ad = 1'b1;
            q.push_back(e);
        end
        for (int i = 0; i < sb + extn; i++) begin
            e = idle_ent(1'b1); e.req = hold_req;
            e.rdy = (i < sb - 1 + ext) ? rdy_pol : ~rdy_pol;
            e.din = 32'hA500_0000 + 32'(i) * 32'h11;
            e.ce_n = 1'b0; e.oe_n = wr; e.we_n = !wr;
            e.be_n = bwe ? (wr ? bev : 4'hF) : bev;
            e.dout_en = wr; e.chk_ad = 1'b1;
            last_din = e.din;
            q.push_back(e);
        end
        if (!tmo) begin
            for (int i = 0; i < hd; i++) begin
                e = idle_ent(1'b1); e.req = hold_req; e.ce_n = ss;
                e.be_n = bwe ? 4'hF : bev; e.dout_en = wr; e.chk_ad = 1'b1;
                q.push_back(e);
            end
        end
        e = idle_ent(1'b1); e.req = hold_req; e.done = 1'b1; e.tmo = tmo;
        e.chk_rd = !wr; e.rd = last_din;
        q.push_back(e);
        for (int i = 0; i < int'(ta_cycles); i++) begin
            e = idle_ent(1'b1); e.req = hold_req;
            q.push_back(e);
        end
    endtask

    task automatic set_req(bit wr, logic [19:0] a, logic [3:0] be, logic [31:0] d);
        req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset
        cur_req = "R1";
        step(); step();
        chk("rd_data", rd_data, 32'h0);

        // R2 / R4: read phases, data capture, done
        cur_req = "R2/R4 read";
        cfg_word = mk_cfg(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, 2);
        set_req(1'b0, 20'h1_2345, 4'hF, '0);
        build(1'b0, 0); run_q(); step();
        cur_req = "R2 minimum phases";
        cfg_word = mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        build(1'b0, 0); run_q(); step();

        // R3: write phases and data drive
        cur_req = "R3 write";
        cfg_word = mk_cfg(0, 0, 0, 2, 5, 2, 0, 0, 0, 0, 2);
        set_req(1'b1, 20'h0_0ABC, 4'b0101, 32'hCAFE_F00D);
        build(1'b0, 0); run_q(); step();

        // R5: stretch, both polarities
        cur_req = "R5 pol high";
        rdy_pol = 1'b1; max_wait = 8'd1;
        cfg_word = mk_cfg(1, 1, 1, 1, 2, 1, 1, 0, 0, 0, 2);
        set_req(1'b0, 20'h0_0010, 4'hF, '0);
        build(1'b0, 5); run_q(); step();
        cur_req = "R5 pol low";
        rdy_pol = 1'b0;
        set_req(1'b1, 20'h0_0020, 4'hC, 32'h1234_5678);
        build(1'b0, 3); run_q(); step();

        // R6: timeout and exact limit
        cur_req = "R6 zero limit";
        rdy_pol = 1'b1; max_wait = 8'd0;
        set_req(1'b0, 20'h0_0030, 4'hF, '0);
        build(1'b0, 3); run_q(); step();
        cur_req = "R6 exact limit";
        max_wait = 8'd1;
        build(1'b0, 16); run_q(); step();
        cur_req = "R6 over limit";
        set_req(1'b1, 20'h0_0040, 4'h3, 32'h5555_AAAA);
        build(1'b0, 17); run_q(); step();

        // R7: ready ignored when stretch disabled
        cur_req = "R7";
        cfg_word = mk_cfg(1, 1, 1, 1, 2, 1, 0, 0, 0, 0, 2);
        set_req(1'b0, 20'h0_0050, 4'hF, '0);
        build(1'b0, 10); run_q(); step();

        // R8 / R12: back-to-back, request held during busy
        cur_req = "R8/R12 ta=3";
        ta_cycles = 3'd3;
        set_req(1'b1, 20'h0_0060, 4'hF, 32'h0000_1111);
        build(1'b1, 0); run_q();
        set_req(1'b0, 20'h0_0070, 4'hF, '0);
        build(1'b1, 0); run_q();
        cur_req = "R8 ta=0";
        ta_cycles = 3'd0;
        set_req(1'b1, 20'h0_0080, 4'h1, 32'h0000_2222);
        build(1'b1, 0); run_q();
        set_req(1'b0, 20'h0_0090, 4'h2, '0);
        build(1'b0, 0); run_q(); step();
        ta_cycles = 3'd7;
        cur_req = "R12 max gap";
        set_req(1'b1, 20'h0_00A0, 4'h9, 32'hDEAD_BEEF);
        build(1'b1, 0); run_q();
        build(1'b0, 0); run_q(); step();
        ta_cycles = 3'd1;

        // R9: byte write strobe mode
        cur_req = "R9 write";
        cfg_word = mk_cfg(1, 2, 1, 1, 2, 1, 0, 1, 0, 0, 2);
        set_req(1'b1, 20'h0_00B0, 4'b0110, 32'h0F0F_0F0F);
        build(1'b0, 0); run_q(); step();
        cur_req = "R9 read";
        set_req(1'b0, 20'h0_00C0, 4'hF, '0);
        build(1'b0, 0); run_q(); step();

        // R10: chip select only during strobe
        cur_req = "R10 read";
        cfg_word = mk_cfg(2, 1, 2, 2, 1, 2, 0, 0, 1, 0, 2);
        set_req(1'b0, 20'h0_00D0, 4'hF, '0);
        build(1'b0, 0); run_q(); step();
        cur_req = "R10 write";
        set_req(1'b1, 20'h0_00E0, 4'hF, 32'h7777_8888);
        build(1'b0, 0); run_q(); step();

        // R11: synchronous region refused
        cur_req = "R11";
        cfg_word = mk_cfg(1, 1, 1, 1, 1, 1, 0, 0, 0, 1, 2);
        set_req(1'b1, 20'h0_00F0, 4'hF, 32'h9999_0000);
        build(1'b0, 0); run_q(); step(); step();

        // R13: lane limit by device width
        cur_req = "R13 8-bit";
        cfg_word = mk_cfg(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        set_req(1'b1, 20'h0_0100, 4'hF, 32'h0000_00AB);
        build(1'b0, 0); run_q(); step();
        cur_req = "R13 16-bit";
        cfg_word = mk_cfg(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        set_req(1'b0, 20'h0_0110, 4'hE, '0);
        build(1'b0, 0); run_q(); step();
        cur_req = "R13 64-bit";
        cfg_word = mk_cfg(0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 3);
        build(1'b0, 0); run_q(); step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule